// File: doc/BRIEF.md
# Serial Memory Status Register and Write Protection Controller

This block holds the status register of a serial memory that is accessed over a mode-0 SPI link. It decodes four one-byte commands: set the write-enable latch, clear the write-enable latch, read the status byte, and write the status byte. It keeps the write-enable latch, a write-in-progress flag, two block-protect bits and a status-lock bit. The two committed block-protect bits are exported on `bp_level`, so that the memory array can decide which region is read-only.

The SPI pins are sampled with the system clock, which must run several times faster than the serial clock. Sampling is on the serial clock's rising edge, MSB first, and the read data changes on the falling edge. A status write is committed only when chip select rises within one serial-clock period after the eighth data bit. The accepted protection bits are then held aside while a self-timed write cycle of `TW_CYCLES` system clocks runs. They replace the live bits, and the write-enable latch clears, only when that cycle ends. When the lock bit is set and the active-low write-protect pin is low, status writes are refused.

Top module: `spi_status_ctrl`

## Requirements
- R1: After synchronous reset the status byte reads 0x00, `bp_level` is 0 and `miso` is 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Each takes effect only if chip select rises after exactly 8 serial-clock rising edges.
- R3: After opcode 0x05, `miso` returns the status byte MSB first for as long as clocks continue. The byte is {lock bit 7, 0, 0, 0, block-protect bits 3:2, write-enable bit 1, write-in-progress bit 0}. Bits 6 to 4 are always 0.
- R4: A status write (opcode 0x01 followed by one data byte) is ignored unless the write-enable latch is set.
- R5: An accepted status write changes only bits 7, 3 and 2, which it takes from the same positions of the data byte.
- R6: A status write is discarded unless chip select rises after exactly 16 rising edges. 15 or 17 edges discard it.
- R7: From the system clock edge that sees chip select high, bit 0 reads 1 for exactly `TW_CYCLES` clocks and then returns to 0. The status can be read during this time.
- R8: The lock and block-protect bits keep their old values throughout the timed cycle. The new values appear, and the write-enable latch clears, when the cycle ends.
- R9: With the lock bit at 1 and `wp_n` low at the chip-select rise, a status write is refused. With `wp_n` high, or with the lock bit at 0, it is accepted.
- R10: Commands 0x06, 0x04 and 0x01 have no effect while a timed cycle is in progress.
- R11: `bp_level` always equals status bits 3:2 as committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low write-protect pin |
| miso | output | 1 | Serial data out of the block |
| bp_level | output | 2 | Committed block-protect level for the array |

## Verification
A sequence of frames walks the status register through its states. Frames without a prior enable are told apart from enabled ones. Lock-plus-pin refusal is told apart from lock with the pin high, and from an unlocked write with the pin low. Frames of 15, 16 and 17 bits show that only the exact window commits. A 9-bit enable frame shows that the byte-boundary rule applies to one-byte commands as well. Timed frames read the register in the middle of the write cycle, to separate the live bits from the pending ones. They also count clocks until `bp_level` changes, which pins down the cycle length.

// File: rtl/spi_status_pkg.sv
package spi_status_pkg;

    localparam int BYTE_W  = 8;
    localparam int BITCNT_W = 5;
    localparam logic [BITCNT_W-1:0] BITCNT_MAX = '1;
    localparam logic [BITCNT_W-1:0] CMD_BITS   = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] WRITE_BITS = BITCNT_W'(2*BYTE_W);

    typedef enum logic [BYTE_W-1:0] {
        OP_WR_STATUS = 8'h01,
        OP_LATCH_CLR = 8'h04,
        OP_RD_STATUS = 8'h05,
        OP_LATCH_SET = 8'h06
    } opcode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
    } prot_t;

    function automatic logic [BYTE_W-1:0] pack_status(prot_t p, logic wel, logic wip);
        return {p.lock, 3'b000, p.bp, wel, wip};
    endfunction

endpackage

// File: rtl/spi_status_rx.sv
module spi_status_rx
    import spi_status_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                mosi,
    input  logic [BYTE_W-1:0]   tx_byte,
    output logic                cs_rise,
    output logic [BITCNT_W-1:0] bit_cnt,
    output logic [BYTE_W-1:0]   opcode,
    output prot_t               rx_prot,
    output logic                miso
);

    logic              sclk_q, cs_q;
    logic              sclk_up, sclk_dn;
    logic [BYTE_W-1:0] shreg, tx_q;
    logic              tx_en;

    assign sclk_up = sclk & ~sclk_q;
    assign sclk_dn = ~sclk & sclk_q;
    assign cs_rise = cs_n & ~cs_q;
    assign rx_prot = '{lock: shreg[7], bp: shreg[3:2]};
    assign tx_en   = (opcode == OP_RD_STATUS) && (bit_cnt >= CMD_BITS);
    assign miso    = tx_en & tx_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            bit_cnt <= '0;
            opcode  <= '0;
            shreg   <= '0;
            tx_q    <= '0;
        end else begin
            if (sclk_up) begin
                shreg <= {shreg[BYTE_W-2:0], mosi};
                if (bit_cnt != BITCNT_MAX)
                    bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CMD_BITS - 1'b1)
                    opcode <= {shreg[BYTE_W-2:0], mosi};
            end
            if (sclk_dn && tx_en) begin
                if (bit_cnt[2:0] == 3'd0)
                    tx_q <= tx_byte;
                else
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // R3
    rd_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (miso == 1'b0));

endmodule

// File: rtl/spi_status_timer.sv
module spi_status_timer #(
    parameter int TW_CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(TW_CYCLES + 1);
    localparam logic [CW-1:0] TW_LOAD = CW'(TW_CYCLES);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= TW_LOAD;
        else if (busy)
            cnt <= cnt - 1'b1;
    end

    // R10
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= TW_LOAD);

endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
    import spi_status_pkg::*;
#(
    parameter int TW_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       wp_n,
    output logic       miso,
    output logic [1:0] bp_level
);

    logic                cs_rise;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   opcode;
    prot_t               rx_prot;
    prot_t               prot_q, pend_q;
    logic                wel_q;
    logic                busy, tmr_done;
    logic                do_set, do_clr, wr_start, hw_locked;
    logic [BYTE_W-1:0]   status_byte;

    assign status_byte = pack_status(prot_q, wel_q, busy);
    assign bp_level    = prot_q.bp;
    assign hw_locked   = prot_q.lock & ~wp_n;

    spi_status_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .tx_byte (status_byte),
        .cs_rise (cs_rise),
        .bit_cnt (bit_cnt),
        .opcode  (opcode),
        .rx_prot (rx_prot),
        .miso    (miso)
    );

    spi_status_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (wr_start),
        .busy  (busy),
        .done  (tmr_done)
    );

    always_comb begin
        do_set   = cs_rise && !busy && (bit_cnt == CMD_BITS) && (opcode == OP_LATCH_SET);
        do_clr   = cs_rise && !busy && (bit_cnt == CMD_BITS) && (opcode == OP_LATCH_CLR);
        wr_start = cs_rise && !busy && (bit_cnt == WRITE_BITS) && (opcode == OP_WR_STATUS)
                   && wel_q && !hw_locked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_q  <= 1'b0;
            prot_q <= '0;
            pend_q <= '0;
        end else begin
            if (tmr_done) begin
                prot_q <= pend_q;
                wel_q  <= 1'b0;
            end else if (do_set) begin
                wel_q <= 1'b1;
            end else if (do_clr) begin
                wel_q <= 1'b0;
            end
            if (wr_start)
                pend_q <= rx_prot;
        end
    end

    // R4
    wr_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel_q));

    // R6
    wr_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(bit_cnt) == WRITE_BITS));

    // R9
    hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(!prot_q.lock || wp_n));

    // R8
    prot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_done |=> $stable(prot_q));

    // R8
    wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_done |=> !wel_q);

    // R10
    wel_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tmr_done) |=> $stable(wel_q));

endmodule

// File: tb/spi_status_ctrl_bench.sv
module spi_status_ctrl_bench;

    localparam int TW   = 400;
    localparam int HALF = 4;
    localparam int NV   = 13;

    // {frame bits MSB-aligned[40:17], bit count[16:9], wp_n[8], expected status[7:0]}
    localparam logic [40:0] VEC [0:NV-1] = '{
        {24'h060000, 8'd8,  1'b1, 8'h02},   // R2 set latch
        {24'h040000, 8'd8,  1'b1, 8'h00},   // R2 clear latch
        {24'h018C00, 8'd16, 1'b1, 8'h00},   // R4 no latch
        {24'h060000, 8'd8,  1'b1, 8'h02},   // R2
        {24'h01FF00, 8'd16, 1'b1, 8'h8C},   // R5 R8 only 7,3,2
        {24'h060000, 8'd8,  1'b1, 8'h8E},   // R2
        {24'h010400, 8'd16, 1'b0, 8'h8E},   // R9 locked by pin
        {24'h010400, 8'd16, 1'b1, 8'h04},   // R9 pin high
        {24'h060000, 8'd8,  1'b1, 8'h06},   // R2
        {24'h018800, 8'd15, 1'b1, 8'h06},   // R6 short
        {24'h018800, 8'd17, 1'b1, 8'h06},   // R6 long
        {24'h010000, 8'd16, 1'b0, 8'h00},   // R9 unlocked, pin low
        {24'h060000, 8'd9,  1'b1, 8'h00}    // R2 not on byte boundary
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    logic [1:0] bp_level;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spi_status_ctrl #(.TW_CYCLES(TW)) u_spi_status_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .wp_n(wp_n), .miso(miso), .bp_level(bp_level)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input logic [23:0] pat, input int nb, input bit raise,
                             output logic [7:0] rd);
        rd = '0;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk) mosi = pat[23-i];
            repeat (HALF) @(negedge clk);
            rd = {rd[6:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        if (raise) begin
            repeat (HALF) @(negedge clk);
            cs_n = 1'b1;
            mosi = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic read_status(output logic [7:0] st);
        spi_frame(24'h050000, 16, 1'b1, st);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] st, dummy;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 miso", miso, 0);
        chk("R1 bp_level", bp_level, 0);
        read_status(st);
        chk("R1 status", st, 8'h00);

        // table walk
        for (int v = 0; v < NV; v++) begin
            wp_n = VEC[v][8];
            spi_frame(VEC[v][40:17], int'(VEC[v][16:9]), 1'b1, dummy);
            wp_n = 1'b1;
            repeat (TW + 20) @(negedge clk);
            read_status(st);
            chk($sformatf("R2/R4/R5/R6/R9 vec%0d status", v), st, VEC[v][7:0]);
            chk($sformatf("R11 vec%0d bp_level", v), bp_level, VEC[v][3:2]);
        end

        // R7 exact cycle length, R11 export
        spi_frame(24'h060000, 8, 1'b1, dummy);
        spi_frame(24'h010C00, 16, 1'b0, dummy);
        @(negedge clk) cs_n = 1'b1;
        n = 0;
        while (bp_level != 2'b11 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R7 cycle length", n, TW + 1);
        chk("R11 bp_level after commit", bp_level, 2'b11);
        repeat (10) @(negedge clk);
        read_status(st);
        chk("R8 latch cleared after commit", st, 8'h0C);

        // R7 R8 R10 mid-cycle reads
        spi_frame(24'h060000, 8, 1'b1, dummy);
        spi_frame(24'h018000, 16, 1'b1, dummy);
        read_status(st);
        chk("R7 R8 mid-cycle status", st, 8'h0F);
        chk("R8 bp_level held", bp_level, 2'b11);
        spi_frame(24'h040000, 8, 1'b1, dummy);
        read_status(st);
        chk("R10 clear ignored while busy", st, 8'h0F);
        repeat (TW) @(negedge clk);
        read_status(st);
        chk("R8 commit lock bit", st, 8'h80);
        chk("R11 bp_level cleared", bp_level, 0);

        // R3 continuous read: second byte also status
        spi_frame(24'h060000, 8, 1'b1, dummy);
        spi_frame(24'h050000, 24, 1'b1, st);
        chk("R3 repeated status byte", st, 8'h82);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule